// File: doc/BRIEF.md
# Two-Endpoint Texel Block Decoder

This block expands one compressed 4x4 tile of texels into sixteen 24-bit RGB colors. A tile arrives as a single 64-bit word that carries two 16-bit endpoint colors and sixteen 2-bit palette codes. When the word is accepted, the block widens both endpoints to 8 bits per channel. It then derives two more palette colors from them and stores the four-entry palette together with the codes. After that it streams the texels out, one per cycle, in raster order.

The block picks its palette mode by comparing the two raw endpoint words as unsigned numbers. If the first endpoint is the larger, the two extra entries are blends at one third and two thirds of the way between the endpoints. Otherwise, entry 2 is the midpoint of the endpoints and entry 3 is forced to black. Each output texel carries its row and column and a flag on the sixteenth texel. A new tile is held off until the previous one has been fully taken.

Top module: `texblk_decoder`

## Requirements
- R1: Endpoint A sits in `in_block[15:0]` and endpoint B in `in_block[31:16]`. Each endpoint packs red in bits [15:11], green in [10:5] and blue in [4:0]. Each channel is widened to 8 bits by repeating its most significant bits below it. `out_rgb` carries red in [23:16], green in [15:8] and blue in [7:0].
- R2: Code 0 outputs widened endpoint A and code 1 outputs widened endpoint B.
- R3: When A > B as unsigned 16-bit words, code 2 outputs floor((2a+b)/3) and code 3 outputs floor((a+2b)/3), each computed per channel on the widened 8-bit values.
- R4: When A <= B, code 2 outputs floor((a+b)/2) per widened channel and code 3 outputs 0x000000.
- R5: When A equals B, the midpoint mode applies: codes 0, 1 and 2 all give the endpoint color and code 3 gives 0x000000.
- R6: Texel k = 4*row + col takes its code from `in_block[32+2k +: 2]`. Texels leave in order k = 0..15 with `out_row`/`out_col` set to row and column. `out_last` is high only on k = 15, and `out_valid` drops after that texel is taken.
- R7: While idle, `in_ready` is high. A tile is accepted on a rising edge where `in_valid` and `in_ready` are both high. Texel 0 is presented with `out_valid` high after that edge, and each edge with `out_valid` and `out_ready` both high advances to the next texel.
- R8: While `out_valid` is high and `out_ready` is low, the texel value, its coordinates and `out_valid` stay unchanged.
- R9: `in_ready` is low from acceptance until texel 15 is taken, and `in_valid` has no effect during that time. `in_ready` is high again in the cycle after the last transfer.
- R10: Synchronous active-high `rst` clears `out_valid`, `out_last` and `out_rgb` to zero and leaves `in_ready` high, including when it arrives in the middle of a tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Compressed tile offered |
| in_ready | output | 1 | Decoder can take a tile |
| in_block | input | 64 | Two endpoints and sixteen 2-bit codes |
| out_valid | output | 1 | A decoded texel is presented |
| out_ready | input | 1 | Consumer takes the presented texel |
| out_rgb | output | 24 | Decoded color, 8 bits per channel |
| out_row | output | 2 | Row of the presented texel |
| out_col | output | 2 | Column of the presented texel |
| out_last | output | 1 | Presented texel is the sixteenth of the tile |

## Verification
Texel 0 is due one rising edge after the accepting edge, so the bench samples it at the next falling edge. Every later texel is due one edge after a transfer, and the bench samples it at the falling edge that follows. Stalled texels are re-sampled after an edge with `out_ready` low, which must leave them unchanged. `in_ready` is due to return one edge after the transfer of texel 15. Reset results are sampled at the falling edge after the reset edge. All samples are taken on falling edges, half a period away from the edge that updates the registers.

// File: rtl/texblk_pkg.sv
package texblk_pkg;
  localparam int CH_W    = 8;
  localparam int RED_W   = 5;
  localparam int GRN_W   = 6;
  localparam int BLU_W   = 5;
  localparam int EP_W    = RED_W + GRN_W + BLU_W;
  localparam int SIDE    = 4;
  localparam int NTEX    = SIDE * SIDE;
  localparam int IDX_W   = 2;
  localparam int NPAL    = 1 << IDX_W;
  localparam int BLK_W   = 2 * EP_W + NTEX * IDX_W;
  localparam int POS_W   = $clog2(NTEX);
  localparam int COORD_W = $clog2(SIDE);
  localparam int PIX_W   = 3 * CH_W;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/texblk_widen.sv
// Widens a narrow channel by repeating its bits from the top down.
module texblk_widen #(
  parameter int IN_W  = 5,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    assign dout[OUT_W-1-i] = din[IN_W-1-(i % IN_W)];
  end
endmodule

// File: rtl/texblk_palette.sv
// Combinational palette builder: two packed endpoints in, four colors out.
module texblk_palette
  import texblk_pkg::*;
#(
  parameter int C_W = CH_W
) (
  input  logic [EP_W-1:0]      ep0,
  input  logic [EP_W-1:0]      ep1,
  output rgb_t [NPAL-1:0]      pal
);
  localparam int SUM_W  = C_W + 2;
  // floor(x/3) == (x*683)>>11 holds for every x below 2048, so C_W <= 9.
  localparam int DIV_K  = 683;
  localparam int DIV_SH = 11;
  localparam int PROD_W = SUM_W + 10;

  function automatic logic [C_W-1:0] third(input logic [SUM_W-1:0] x);
    logic [PROD_W-1:0] p;
    p = PROD_W'(x) * PROD_W'(DIV_K);
    return C_W'(p >> DIV_SH);
  endfunction

  logic [1:0][EP_W-1:0]         eps;
  logic [1:0][2:0][C_W-1:0]     ch;     // [endpoint][2=red,1=green,0=blue]
  logic [2:0][C_W-1:0]          near_t, far_t, mid_t;
  logic                         mid_mode;

  assign eps      = {ep1, ep0};
  assign mid_mode = (ep0 <= ep1);

  for (genvar e = 0; e < 2; e++) begin : g_ep
    texblk_widen #(.IN_W(RED_W), .OUT_W(C_W)) u_red (
      .din (eps[e][EP_W-1 -: RED_W]),
      .dout(ch[e][2])
    );
    texblk_widen #(.IN_W(GRN_W), .OUT_W(C_W)) u_grn (
      .din (eps[e][BLU_W +: GRN_W]),
      .dout(ch[e][1])
    );
    texblk_widen #(.IN_W(BLU_W), .OUT_W(C_W)) u_blu (
      .din (eps[e][BLU_W-1:0]),
      .dout(ch[e][0])
    );
  end

  for (genvar k = 0; k < 3; k++) begin : g_ch
    logic [SUM_W-1:0] s_near, s_far, s_mid;
    assign s_near    = {1'b0, ch[0][k], 1'b0} + SUM_W'(ch[1][k]);
    assign s_far     = SUM_W'(ch[0][k]) + {1'b0, ch[1][k], 1'b0};
    assign s_mid     = SUM_W'(ch[0][k]) + SUM_W'(ch[1][k]);
    assign near_t[k] = third(s_near);
    assign far_t[k]  = third(s_far);
    assign mid_t[k]  = s_mid[C_W:1];

    always_comb begin
      // R3
      third_near_chk: assert ((SUM_W'(near_t[k]) * SUM_W'(3)) <= s_near &&
                              s_near < (SUM_W'(near_t[k]) * SUM_W'(3)) + SUM_W'(3));
      // R3
      third_far_chk: assert ((SUM_W'(far_t[k]) * SUM_W'(3)) <= s_far &&
                             s_far < (SUM_W'(far_t[k]) * SUM_W'(3)) + SUM_W'(3));
    end
  end

  assign pal[0] = ch[0];
  assign pal[1] = ch[1];
  assign pal[2] = mid_mode ? mid_t : near_t;
  assign pal[3] = mid_mode ? '0    : far_t;
endmodule

// File: rtl/texblk_stream.sv
// Holds the palette and codes of one tile and presents its texels in order.
module texblk_stream
  import texblk_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [NTEX*IDX_W-1:0]   idx_in,
  input  rgb_t [NPAL-1:0]         pal_in,
  output logic                    out_valid,
  input  logic                    out_ready,
  output rgb_t                    out_pix,
  output logic [COORD_W-1:0]      out_row,
  output logic [COORD_W-1:0]      out_col,
  output logic                    out_last
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(NTEX - 1);

  rgb_t [NPAL-1:0]         pal_q;
  logic [NTEX*IDX_W-1:0]   idx_q;
  logic [POS_W-1:0]        pos_q;
  logic [POS_W-1:0]        pos_nx;
  logic                    valid_q;
  rgb_t                    pix_q;
  logic                    accept, take, at_end;

  function automatic logic [IDX_W-1:0] code_at(input logic [NTEX*IDX_W-1:0] v,
                                               input logic [POS_W-1:0] p);
    return v[p*IDX_W +: IDX_W];
  endfunction

  assign in_ready = !valid_q;
  assign accept   = in_valid && in_ready;
  assign take     = valid_q && out_ready;
  assign at_end   = (pos_q == LAST_POS);
  assign pos_nx   = pos_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      pos_q   <= '0;
      pix_q   <= '0;
    end else if (accept) begin
      pal_q   <= pal_in;
      idx_q   <= idx_in;
      pos_q   <= '0;
      valid_q <= 1'b1;
      pix_q   <= pal_in[code_at(idx_in, '0)];
    end else if (take) begin
      if (at_end) begin
        valid_q <= 1'b0;
      end else begin
        pos_q <= pos_nx;
        pix_q <= pal_q[code_at(idx_q, pos_nx)];
      end
    end
  end

  assign out_valid = valid_q;
  assign out_pix   = pix_q;
  assign out_row   = pos_q[POS_W-1 -: COORD_W];
  assign out_col   = pos_q[COORD_W-1:0];
  assign out_last  = valid_q && at_end;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !out_ready) |=> (valid_q && $stable(pix_q) && $stable(pos_q)));
  // R6
  raster_step_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !at_end) |=> (valid_q && pos_q == $past(pos_q) + 1'b1));
  // R9
  tile_done_chk: assert property (@(posedge clk) disable iff (rst)
    (take && at_end) |=> (!valid_q && in_ready));
  // R7
  tile_load_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (valid_q && pos_q == '0));
endmodule

// File: rtl/texblk_decoder.sv
module texblk_decoder
  import texblk_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [BLK_W-1:0]    in_block,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [PIX_W-1:0]    out_rgb,
  output logic [COORD_W-1:0]  out_row,
  output logic [COORD_W-1:0]  out_col,
  output logic                out_last
);
  rgb_t [NPAL-1:0] pal_w;
  rgb_t            pix_w;

  texblk_palette u_pal (
    .ep0(in_block[EP_W-1:0]),
    .ep1(in_block[2*EP_W-1:EP_W]),
    .pal(pal_w)
  );

  texblk_stream u_seq (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .idx_in   (in_block[BLK_W-1:2*EP_W]),
    .pal_in   (pal_w),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_pix  (pix_w),
    .out_row  (out_row),
    .out_col  (out_col),
    .out_last (out_last)
  );

  assign out_rgb = pix_w;
endmodule

// File: tb/tb_texblk_decoder.sv
module tb_texblk_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  localparam logic [63:0] VEC [NVEC] = '{
    64'hE4E4E4E4_0000FFFF,   // A>B white/black
    64'hE4E4E4E4_FFFF0000,   // A<B midpoint mode
    64'h1BE44EB1_84108410,   // equal endpoints
    64'h1B1B1B1B_07E0F800,   // red over green
    64'h9C6A3F51_ABCD1234,   // A<B mixed
    64'hF00FA55A_1234ABCD,   // A>B mixed
    64'hFFAA5500_001E001F    // A exceeds B by one
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_block = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] out_rgb;
  logic [1:0]  out_row, out_col;
  logic        out_last;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  texblk_decoder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .out_valid(out_valid), .out_ready(out_ready),
    .out_rgb(out_rgb), .out_row(out_row), .out_col(out_col), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int w5(input int v); return (v << 3) | (v >> 2); endfunction
  function automatic int w6(input int v); return (v << 2) | (v >> 4); endfunction

  function automatic logic [23:0] ref_pix(input logic [63:0] blk, input int k);
    logic [15:0] a = blk[15:0];
    logic [15:0] b = blk[31:16];
    int code = int'(blk[32+2*k +: 2]);
    int ca[3], cb[3], e[3];
    ca[0] = w5(int'(a[15:11])); ca[1] = w6(int'(a[10:5])); ca[2] = w5(int'(a[4:0]));
    cb[0] = w5(int'(b[15:11])); cb[1] = w6(int'(b[10:5])); cb[2] = w5(int'(b[4:0]));
    for (int c = 0; c < 3; c++) begin
      case (code)
        0: e[c] = ca[c];
        1: e[c] = cb[c];
        2: e[c] = (a > b) ? (2*ca[c] + cb[c]) / 3 : (ca[c] + cb[c]) / 2;
        default: e[c] = (a > b) ? (ca[c] + 2*cb[c]) / 3 : 0;
      endcase
    end
    return {e[0][7:0], e[1][7:0], e[2][7:0]};
  endfunction

  function automatic string req_of(input logic [63:0] blk, input int k);
    int code = int'(blk[32+2*k +: 2]);
    if (blk[15:0] == blk[31:16]) return "R5";
    if (code < 2) return "R1 R2";
    return (blk[15:0] > blk[31:16]) ? "R3" : "R4";
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Call at a falling edge; returns at the falling edge after the accepting edge.
  task automatic send(input logic [63:0] blk);
    chk(in_ready == 1'b1, "R7 idle ready", 64'(in_ready), 64'd1);
    in_valid = 1'b1;
    in_block = blk;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_block = '0;
  endtask

  task automatic drain(input logic [63:0] blk, input bit stall, input bit intrude);
    for (int k = 0; k < 16; k++) begin
      logic [23:0] exp_pix = ref_pix(blk, k);
      chk(out_valid == 1'b1, "R7 valid", 64'(out_valid), 64'd1);
      chk(out_rgb == exp_pix, req_of(blk, k), 64'(out_rgb), 64'(exp_pix));
      chk({out_row, out_col} == 4'(k), "R6 coord", 64'({out_row, out_col}), 64'(k));
      chk(out_last == (k == 15), "R6 last", 64'(out_last), 64'(k == 15));
      if (intrude && k >= 5 && k <= 9) begin
        in_valid = 1'b1;
        in_block = ~blk;
        chk(in_ready == 1'b0, "R9 busy", 64'(in_ready), 64'd0);
      end else begin
        in_valid = 1'b0;
      end
      if (stall && (k % 3 == 1)) begin
        out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(out_valid && out_rgb == exp_pix, "R8 hold", 64'(out_rgb), 64'(exp_pix));
        chk({out_row, out_col} == 4'(k), "R8 coord", 64'({out_row, out_col}), 64'(k));
      end
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R6 end", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R9 ready again", 64'(in_ready), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk(out_valid == 1'b0, "R10 valid", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R10 ready", 64'(in_ready), 64'd1);
    chk(out_last == 1'b0, "R10 last", 64'(out_last), 64'd0);
    chk(out_rgb == 24'd0, "R10 rgb", 64'(out_rgb), 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i]);
      drain(VEC[i], i == 4, i == 2);
    end

    // R7: texel 0 is not visible before the accepting edge
    in_valid = 1'b1;
    in_block = VEC[5];
    chk(out_valid == 1'b0, "R7 latency", 64'(out_valid), 64'd0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    drain(VEC[5], 1'b1, 1'b1);

    // R10 reset in the middle of a tile
    send(VEC[3]);
    out_ready = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 1'b0, "R10 mid valid", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R10 mid ready", 64'(in_ready), 64'd1);
    chk(out_rgb == 24'd0, "R10 mid rgb", 64'(out_rgb), 64'd0);
    send(VEC[6]);
    drain(VEC[6], 1'b0, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule